// File: doc/BRIEF.md
# Sequential Unsigned Wide Divider with Condition Flags

This block divides a double-width unsigned dividend by a single-width unsigned divisor. With the default parameter it takes a 32-bit dividend and a 16-bit divisor. It returns one packed double-width word. The quotient fills the lower half of that word and the remainder fills the upper half. The packing lets the surrounding datapath write the whole word back into the accumulator pair that supplied the dividend.

A one-cycle start strobe accepts a new operation. The block first tests whether the quotient will fit in the lower half. When it will not, which includes a zero divisor, the operation ends at once. The overflow flag is raised and the packed result register keeps its previous value. When it fits, a restoring shift-subtract loop produces one quotient bit per clock. A done strobe then marks the cycle in which the result and the flags are valid.

Three flags come out, each with a write enable: sign, zero and overflow. The sign flag is always written as 0. The zero flag reports a zero quotient, and the overflow flag reports that the quotient did not fit. The carry write enable is held low so that the caller's carry keeps its value.

The controller has four states:
- `ST_IDLE` waits for start.
- `ST_STEP` runs the iterations.
- `ST_DONE` presents a completed division.
- `ST_OVF` presents an overflow.

The controller has these transitions:
- `ST_IDLE`→`ST_STEP`: start with no overflow.
- `ST_IDLE`→`ST_OVF`: start with overflow.
- `ST_STEP`→`ST_STEP`: an iteration that is not the last.
- `ST_STEP`→`ST_DONE`: the last iteration.
- `ST_DONE`→`ST_IDLE` and `ST_OVF`→`ST_IDLE`: always, after one cycle.

Top module: `wdiv_unit`

## Requirements
- R1: With no overflow, result bits [HALF_W-1:0] hold the quotient and bits [2*HALF_W-1:HALF_W] hold the remainder. The quotient times the divisor plus the remainder equals the dividend, and the remainder is below the divisor.
- R2: Overflow is detected when dividend bits [2*HALF_W-1:HALF_W] are greater than or equal to the divisor, which includes a zero divisor. Overflow sets flag_ovf_o to 1 in the done cycle and leaves result_o at its previous value.
- R3: flag_sign_o is 0 in every done cycle.
- R4: In a done cycle without overflow, flag_zero_o is 1 exactly when the quotient is zero. In an overflow done cycle, flag_zero_o is 0.
- R5: flag_ovf_o is 0 in a done cycle without overflow.
- R6: we_sign_o, we_zero_o and we_ovf_o are 1 exactly in done cycles. we_carry_o is never 1.
- R7: done_o is high for a single cycle. It rises HALF_W+1 cycles after the clock edge that samples start without overflow, which is 17 cycles by default. It rises 1 cycle after that edge on overflow.
- R8: A start that arrives while an operation is in progress, including during the done cycle, is ignored. The operands latched for the running operation decide its result.
- R9: After reset, done_o and all write enables are 0 and result_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe, sampled in the idle state |
| dividend_i | input | 2*HALF_W | Unsigned dividend |
| divisor_i | input | HALF_W | Unsigned divisor |
| result_o | output | 2*HALF_W | Packed result: remainder high, quotient low |
| done_o | output | 1 | One-cycle completion strobe |
| flag_sign_o | output | 1 | Sign flag value |
| flag_zero_o | output | 1 | Zero flag value |
| flag_ovf_o | output | 1 | Overflow flag value |
| we_sign_o | output | 1 | Write enable for the sign flag |
| we_zero_o | output | 1 | Write enable for the zero flag |
| we_ovf_o | output | 1 | Write enable for the overflow flag |
| we_carry_o | output | 1 | Write enable for carry, always 0 |

## Verification
A 4-bit-divisor instance is swept over every dividend and divisor pair, which is 4096 operations. The sweep covers the boundary where the upper dividend half equals the divisor, which must overflow, and the boundary one below it, which must not. It also covers a zero divisor and zero quotients, which separate the zero flag from the overflow case. On part of the vectors a second start is driven in the middle of the run, to show that the latched operands are the ones that count. A short list of default-width vectors checks the 17-cycle latency and the 16-bit packing at full size, including the largest quotient that fits and a remainder of divisor minus one.

// File: rtl/wdiv_pkg.sv
package wdiv_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_STEP = 2'd1,
        ST_DONE = 2'd2,
        ST_OVF  = 2'd3
    } wdiv_state_e;
endpackage

// File: rtl/wdiv_ctrl.sv
module wdiv_ctrl
    import wdiv_pkg::*;
#(
    parameter int HALF_W = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_i,
    input  logic        ovf_i,
    output wdiv_state_e state_o,
    output logic        load_o,
    output logic        step_o,
    output logic        last_o
);
    localparam int CW = (HALF_W > 1) ? $clog2(HALF_W) : 1;
    localparam logic [CW-1:0] LAST_CNT = CW'(HALF_W - 1);

    wdiv_state_e state_q, state_d;
    logic [CW-1:0] cnt_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // iteration counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt_q <= '0;
        else if (load_o) cnt_q <= '0;
        else if (step_o) cnt_q <= cnt_q + 1'b1;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_i) state_d = ovf_i ? ST_OVF : ST_STEP;
            ST_STEP: if (cnt_q == LAST_CNT) state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
            ST_OVF:  state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        load_o = 1'b0;
        step_o = 1'b0;
        last_o = 1'b0;
        unique case (state_q)
            ST_IDLE: load_o = start_i && !ovf_i;
            ST_STEP: begin
                step_o = 1'b1;
                last_o = (cnt_q == LAST_CNT);
            end
            ST_DONE: ;
            ST_OVF:  ;
        endcase
    end

    assign state_o = state_q;
endmodule

// File: rtl/wdiv_datapath.sv
module wdiv_datapath #(
    parameter int HALF_W = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [2*HALF_W-1:0]   dividend_i,
    input  logic [HALF_W-1:0]     divisor_i,
    input  logic                  load_i,
    input  logic                  step_i,
    input  logic                  last_i,
    output logic                  ovf_o,
    output logic [2*HALF_W-1:0]   result_o
);
    localparam int FW = 2 * HALF_W;

    logic [HALF_W-1:0] rem_q, quo_q, dsr_q, rem_n, quo_n;
    logic [HALF_W:0]   wide, diff;
    logic              fits;
    logic [FW-1:0]     res_q;

    // quotient overflows unless the upper half is below the divisor
    assign ovf_o = (dividend_i[FW-1:HALF_W] >= divisor_i);

    // one restoring step: shift in the next dividend bit, try the subtract
    always_comb begin
        wide  = {rem_q, quo_q[HALF_W-1]};
        diff  = wide - {1'b0, dsr_q};
        fits  = (wide >= {1'b0, dsr_q});
        rem_n = fits ? diff[HALF_W-1:0] : wide[HALF_W-1:0];
        quo_n = {quo_q[HALF_W-2:0], fits};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q <= '0;
            quo_q <= '0;
            dsr_q <= '0;
        end else if (load_i) begin
            rem_q <= dividend_i[FW-1:HALF_W];
            quo_q <= dividend_i[HALF_W-1:0];
            dsr_q <= divisor_i;
        end else if (step_i) begin
            rem_q <= rem_n;
            quo_q <= quo_n;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      res_q <= '0;
        else if (last_i) res_q <= {rem_n, quo_n};
    end

    assign result_o = res_q;
endmodule

// File: rtl/wdiv_flags.sv
module wdiv_flags
    import wdiv_pkg::*;
#(
    parameter int HALF_W = 16
) (
    input  wdiv_state_e       state_i,
    input  logic [HALF_W-1:0] quotient_i,
    output logic              done_o,
    output logic              flag_sign_o,
    output logic              flag_zero_o,
    output logic              flag_ovf_o,
    output logic              we_sign_o,
    output logic              we_zero_o,
    output logic              we_ovf_o,
    output logic              we_carry_o
);
    always_comb begin
        done_o      = 1'b0;
        flag_sign_o = 1'b0;
        flag_zero_o = 1'b0;
        flag_ovf_o  = 1'b0;
        we_sign_o   = 1'b0;
        we_zero_o   = 1'b0;
        we_ovf_o    = 1'b0;
        we_carry_o  = 1'b0;
        unique case (state_i)
            ST_IDLE: ;
            ST_STEP: ;
            ST_DONE: begin
                done_o      = 1'b1;
                flag_zero_o = (quotient_i == '0);
                we_sign_o   = 1'b1;
                we_zero_o   = 1'b1;
                we_ovf_o    = 1'b1;
            end
            ST_OVF: begin
                done_o     = 1'b1;
                flag_ovf_o = 1'b1;
                we_sign_o  = 1'b1;
                we_zero_o  = 1'b1;
                we_ovf_o   = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/wdiv_unit.sv
module wdiv_unit
    import wdiv_pkg::*;
#(
    parameter int HALF_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [2*HALF_W-1:0] dividend_i,
    input  logic [HALF_W-1:0]   divisor_i,
    output logic [2*HALF_W-1:0] result_o,
    output logic                done_o,
    output logic                flag_sign_o,
    output logic                flag_zero_o,
    output logic                flag_ovf_o,
    output logic                we_sign_o,
    output logic                we_zero_o,
    output logic                we_ovf_o,
    output logic                we_carry_o
);
    wdiv_state_e state;
    logic        ovf, load, step, last;

    wdiv_ctrl #(.HALF_W(HALF_W)) ctrl_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .ovf_i(ovf),
        .state_o(state), .load_o(load), .step_o(step), .last_o(last)
    );

    wdiv_datapath #(.HALF_W(HALF_W)) dp_i (
        .clk(clk), .rst_n(rst_n), .dividend_i(dividend_i), .divisor_i(divisor_i),
        .load_i(load), .step_i(step), .last_i(last), .ovf_o(ovf), .result_o(result_o)
    );

    wdiv_flags #(.HALF_W(HALF_W)) flags_i (
        .state_i(state), .quotient_i(result_o[HALF_W-1:0]),
        .done_o(done_o), .flag_sign_o(flag_sign_o), .flag_zero_o(flag_zero_o),
        .flag_ovf_o(flag_ovf_o), .we_sign_o(we_sign_o), .we_zero_o(we_zero_o),
        .we_ovf_o(we_ovf_o), .we_carry_o(we_carry_o)
    );
endmodule

// File: rtl/wdiv_unit_chk.sv
module wdiv_unit_chk #(
    parameter int HALF_W = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic                start_i,
    input logic [2*HALF_W-1:0] dividend_i,
    input logic [HALF_W-1:0]   divisor_i,
    input logic [2*HALF_W-1:0] result_o,
    input logic                done_o,
    input logic                flag_sign_o,
    input logic                flag_zero_o,
    input logic                flag_ovf_o,
    input logic                we_sign_o,
    input logic                we_zero_o,
    input logic                we_ovf_o,
    input logic                we_carry_o
);
    localparam int FW = 2 * HALF_W;
    localparam int LW = $clog2(HALF_W + 2) + 1;

    logic              pend_q;
    logic [FW-1:0]     cap_a;
    logic [HALF_W-1:0] cap_d;
    logic [LW-1:0]     lat_q;
    logic [FW-1:0]     rebuilt;
    logic              exp_ovf;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            cap_a  <= '0;
            cap_d  <= '0;
            lat_q  <= '0;
        end else if (!pend_q && start_i) begin
            pend_q <= 1'b1;
            cap_a  <= dividend_i;
            cap_d  <= divisor_i;
            lat_q  <= LW'(1);
        end else if (pend_q) begin
            if (done_o) pend_q <= 1'b0;
            lat_q <= lat_q + 1'b1;
        end
    end

    always_comb begin
        rebuilt = ({{HALF_W{1'b0}}, result_o[HALF_W-1:0]} * {{HALF_W{1'b0}}, cap_d})
                + {{HALF_W{1'b0}}, result_o[FW-1:HALF_W]};
        exp_ovf = (cap_a[FW-1:HALF_W] >= cap_d);
    end

    AST_QUOT_REM_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !exp_ovf) |-> (rebuilt == cap_a && result_o[FW-1:HALF_W] < cap_d)); // R1
    AST_OVF_DETECT: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (flag_ovf_o == exp_ovf)); // R2
    AST_OVF_HOLDS_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && flag_ovf_o) |-> $stable(result_o)); // R2
    AST_SIGN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !flag_sign_o); // R3
    AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (flag_zero_o == (!exp_ovf && result_o[HALF_W-1:0] == '0))); // R4
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !exp_ovf) |-> !flag_ovf_o); // R5
    AST_ENABLES: assert property (@(posedge clk) disable iff (!rst_n)
        (we_sign_o == done_o) && (we_zero_o == done_o) && (we_ovf_o == done_o) && !we_carry_o); // R6
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R7
    AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (pend_q && lat_q == (exp_ovf ? LW'(1) : LW'(HALF_W + 1)))); // R7 R8
endmodule

bind wdiv_unit wdiv_unit_chk #(.HALF_W(HALF_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .dividend_i(dividend_i),
    .divisor_i(divisor_i), .result_o(result_o), .done_o(done_o),
    .flag_sign_o(flag_sign_o), .flag_zero_o(flag_zero_o), .flag_ovf_o(flag_ovf_o),
    .we_sign_o(we_sign_o), .we_zero_o(we_zero_o), .we_ovf_o(we_ovf_o),
    .we_carry_o(we_carry_o)
);

// File: tb/wdiv_unit_tb_top.sv
`timescale 1ns/1ps
module wdiv_unit_tb_top;
    localparam int SW = 4;
    localparam int WW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    int n_checks = 0;
    int n_fail = 0;

    // small instance
    logic            s_start = 1'b0;
    logic [2*SW-1:0] s_a = '0;
    logic [SW-1:0]   s_d = '0;
    logic [2*SW-1:0] s_res;
    logic s_done, s_fs, s_fz, s_fv, s_ws, s_wz, s_wv, s_wc;

    wdiv_unit #(.HALF_W(SW)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(s_start), .dividend_i(s_a), .divisor_i(s_d),
        .result_o(s_res), .done_o(s_done), .flag_sign_o(s_fs), .flag_zero_o(s_fz),
        .flag_ovf_o(s_fv), .we_sign_o(s_ws), .we_zero_o(s_wz), .we_ovf_o(s_wv),
        .we_carry_o(s_wc)
    );

    // default-width instance
    logic            w_start = 1'b0;
    logic [2*WW-1:0] w_a = '0;
    logic [WW-1:0]   w_d = '0;
    logic [2*WW-1:0] w_res;
    logic w_done, w_fs, w_fz, w_fv, w_ws, w_wz, w_wv, w_wc;

    wdiv_unit dut_w_i (
        .clk(clk), .rst_n(rst_n), .start_i(w_start), .dividend_i(w_a), .divisor_i(w_d),
        .result_o(w_res), .done_o(w_done), .flag_sign_o(w_fs), .flag_zero_o(w_fz),
        .flag_ovf_o(w_fv), .we_sign_o(w_ws), .we_zero_o(w_wz), .we_ovf_o(w_wv),
        .we_carry_o(w_wc)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    logic [2*SW-1:0] s_last = '0;
    logic [2*WW-1:0] w_last = '0;

    task automatic run_small(input logic [2*SW-1:0] a, input logic [SW-1:0] d, input bit inject);
        bit ovf;
        logic [2*SW-1:0] exp;
        int n;
        ovf = (a[2*SW-1:SW] >= d);
        exp = ovf ? s_last : {(2*SW)'(a % d)} << SW | (2*SW)'(a / d);
        @(negedge clk);
        s_start = 1'b1; s_a = a; s_d = d;
        @(negedge clk);
        s_start = 1'b0;
        n = 1;
        while (!s_done && n < 40) begin
            if (inject && n == 3) begin s_start = 1'b1; s_a = ~a; s_d = d + 1'b1; end // R8
            @(negedge clk);
            s_start = 1'b0;
            n++;
        end
        chk(n == (ovf ? 1 : SW + 1), "R7 latency", n, ovf ? 1 : SW + 1);
        chk(s_res == exp, ovf ? "R2 result held" : (inject ? "R8 result" : "R1 result"), s_res, exp);
        chk(s_fv == ovf, ovf ? "R2 ovf flag" : "R5 ovf flag", s_fv, ovf);
        chk(s_fs == 1'b0, "R3 sign", s_fs, 0);
        chk(s_fz == (!ovf && exp[SW-1:0] == 0), "R4 zero", s_fz, !ovf && exp[SW-1:0] == 0);
        chk(s_ws && s_wz && s_wv && !s_wc, "R6 enables", {s_ws, s_wz, s_wv, s_wc}, 4'b1110);
        s_start = 1'b1; s_a = 8'h01; s_d = 4'h1; // R8: start in done cycle ignored
        @(negedge clk);
        s_start = 1'b0;
        chk(!s_done && !s_ws && !s_wc, "R7 single pulse", s_done, 0);
        s_last = exp;
    endtask

    task automatic run_wide(input logic [2*WW-1:0] a, input logic [WW-1:0] d);
        bit ovf;
        logic [2*WW-1:0] exp;
        int n;
        ovf = (a[2*WW-1:WW] >= d);
        exp = ovf ? w_last : ({(2*WW)'(a % d)} << WW) | (2*WW)'(a / d);
        @(negedge clk);
        w_start = 1'b1; w_a = a; w_d = d;
        @(negedge clk);
        w_start = 1'b0;
        n = 1;
        while (!w_done && n < 60) begin @(negedge clk); n++; end
        chk(n == (ovf ? 1 : WW + 1), "R7 wide latency", n, ovf ? 1 : WW + 1);
        chk(w_res == exp, ovf ? "R2 wide held" : "R1 wide result", w_res, exp);
        chk(w_fv == ovf && !w_fs && !w_wc, "R2 R3 R6 wide flags", {w_fv, w_fs, w_wc}, {ovf, 2'b00});
        chk(w_fz == (!ovf && exp[WW-1:0] == 0), "R4 wide zero", w_fz, !ovf && exp[WW-1:0] == 0);
        @(negedge clk);
        w_last = exp;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R9 reset state
        chk(s_res == 0 && !s_done && !s_ws && !s_wz && !s_wv && !s_wc, "R9 reset", s_res, 0);
        chk(w_res == 0 && !w_done && !w_ws && !w_wc, "R9 reset wide", w_res, 0);
        rst_n = 1'b1;
        for (int a = 0; a < (1 << 2*SW); a++)
            for (int d = 0; d < (1 << SW); d++)
                run_small(a[2*SW-1:0], d[SW-1:0], ((a + d) % 5) == 0);
        run_wide(32'h0001_2345, 16'h0007);
        run_wide(32'hFFFE_FFFF, 16'hFFFF);   // largest fitting quotient, remainder d-1
        run_wide(32'h0000_0003, 16'h0010);   // zero quotient
        run_wide(32'h0010_0000, 16'h0010);   // upper half equals divisor
        run_wide(32'h1234_5678, 16'h0000);   // zero divisor
        run_wide(32'h000F_FFFF, 16'h0010);   // one below the boundary
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule